// File: doc/BRIEF.md
# Keyboard Password Wake-Up Matcher

This block sits beside a keyboard byte receiver in the always-on domain. While the system sleeps, it watches each received scan-code byte. When the stored password has been typed, it drives a low-active wake pulse toward the power-switch logic. The password is held as up to five key records of three bytes each: one make byte, then two break bytes. Matching needs the whole ordered byte stream of every key.

The host fills the fifteen-byte store through two registers. The first is a 4-bit index that selects one byte. The second is a data port that writes, or returns, the byte the index points to. A wake is accepted only while the arm bit is set. A wake clears the arm bit and sets a status bit, and both stay that way until the host arms the block again.

A mode input replaces the password with any-key wake. A mouse enable, together with a button select, adds a wake on a left-button or a right-button click.

Top module: `kbd_wake_matcher`

## Requirements
- R1: After reset `wake_n` is 1, `wake_armed` and `wake_status` are 0, every storage byte is 00h, and `rd_data` reads 00h.
- R2: A write on `idx_wr` loads the index from `idx_wdata[3:0]`. A write on `dat_wr` stores `dat_wdata` at the indexed byte (00h to 0Eh), and `rd_data` always shows that byte. At index 0Fh, writes are dropped and `rd_data` is 00h.
- R3: Key k occupies bytes 3k (make), 3k+1 and 3k+2 (break). In password mode (`any_key` = 0), the password is the byte sequence of keys 0, 1, … in order. The match event happens on the clock edge that accepts its final byte.
- R4: A key whose three bytes are all 00h ends the password, so keys 1 to 4 can be left unused. A shorter password matches once all of its keys have been seen.
- R5: A byte that differs from the next expected byte restarts the matcher. That same byte is then compared at once against byte 0, and a hit on byte 0 counts as the first byte of a new attempt.
- R6: With `any_key` = 1, any valid scan byte is a wake event, whatever is stored.
- R7: With `mouse_en` = 1, a click whose `ms_right` equals `mouse_sel_right` is a wake event (0 = left, 1 = right). The other button, and any click while `mouse_en` = 0, has no effect.
- R8: A wake event taken while armed drives `wake_n` low for exactly 16 cycles, starting in the cycle after the event edge.
- R9: A taken wake clears `wake_armed`. Events are ignored until `arm` sets it again.
- R10: `wake_status` sets on a taken wake and clears on `arm`.
- R11: When key 0 is empty, password mode never produces a wake event.
- R12: A storage write returns the matcher to the start, so a partly typed password must be retyped from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_wr | input | 1 | Index register write strobe |
| idx_wdata | input | 4 | New index value |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte stored at the index |
| rd_data | output | 8 | Byte at the current index |
| kb_valid | input | 1 | One received scan-code byte this cycle |
| kb_byte | input | 8 | Received scan-code byte |
| ms_click | input | 1 | One mouse button click this cycle |
| ms_right | input | 1 | Clicked button: 0 left, 1 right |
| any_key | input | 1 | Wake source: 0 password, 1 any key |
| mouse_en | input | 1 | Enable mouse-click wake |
| mouse_sel_right | input | 1 | Button that wakes: 0 left, 1 right |
| arm | input | 1 | Set the wake enable and clear the status |
| wake_armed | output | 1 | Wake enable bit, cleared by a taken wake |
| wake_status | output | 1 | A wake has been taken since the last arm |
| wake_n | output | 1 | Low-active wake pulse |

## Verification
The hardest case is the recovery inside a sequence. A byte that breaks a partial match must also be checked as the start of a new match. Only a stream that repeats the first key's bytes just before the second key exposes this. The bench programs a two-key password and types the first key twice in a row, then the second key. A wake therefore shows that the repeated make byte was re-used. A separate partial-then-write stream checks that storage updates discard progress.

// File: rtl/kbd_wake_matcher.sv
module kbd_wake_matcher #(
  parameter int KEYS      = 5,
  parameter int KEY_BYTES = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [3:0] idx_wdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [7:0] rd_data,
  input  logic       kb_valid,
  input  logic [7:0] kb_byte,
  input  logic       ms_click,
  input  logic       ms_right,
  input  logic       any_key,
  input  logic       mouse_en,
  input  logic       mouse_sel_right,
  input  logic       arm,
  output logic       wake_armed,
  output logic       wake_status,
  output logic       wake_n
);
  localparam int NBYTES = KEYS * KEY_BYTES;
  localparam int PW     = $clog2(NBYTES + 1);
  localparam int CW     = $clog2(PULSE_LEN + 1);

  logic [7:0]    mem [NBYTES];
  logic [3:0]    idx_q;
  logic [PW-1:0] pos_q, total;
  logic [KEYS-1:0] key_nz;
  logic [CW-1:0] cnt_q;
  logic          hit, restart_hit, pw_done, ev, fire, idx_ok;

  assign idx_ok  = 32'(idx_q) < NBYTES;
  assign rd_data = idx_ok ? mem[idx_q[PW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= idx_wdata;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mem[b] <= 8'h00;
      else if (dat_wr && 32'(idx_q) == b) mem[b] <= dat_wdata;
  end

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    logic [7:0] any_bits;
    always_comb begin
      any_bits = 8'h00;
      for (int j = 0; j < KEY_BYTES; j++) any_bits |= mem[k*KEY_BYTES + j];
    end
    assign key_nz[k] = |any_bits;
  end

  always_comb begin
    logic stop;
    stop  = 1'b0;
    total = '0;
    for (int k = 0; k < KEYS; k++) begin
      if (!stop && key_nz[k]) total = total + PW'(KEY_BYTES);
      else stop = 1'b1;
    end
  end

  assign hit         = kb_valid && total != '0 && kb_byte == mem[pos_q];
  assign restart_hit = kb_valid && total != '0 && kb_byte == mem[0];
  assign pw_done     = hit && (pos_q + 1'b1 == total);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pos_q <= '0;
    else if (dat_wr) pos_q <= '0;
    else if (kb_valid && total != '0) begin
      if (hit) pos_q <= pw_done ? '0 : pos_q + 1'b1;
      else     pos_q <= restart_hit ? PW'(1) : '0;
    end

  assign ev   = (any_key ? kb_valid : pw_done) ||
                (mouse_en && ms_click && ms_right == mouse_sel_right);
  assign fire = ev && wake_armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_armed  <= 1'b0;
      wake_status <= 1'b0;
      cnt_q       <= '0;
    end else begin
      if (fire)     wake_armed <= 1'b0;
      else if (arm) wake_armed <= 1'b1;
      if (fire)     wake_status <= 1'b1;
      else if (arm) wake_status <= 1'b0;
      if (fire)               cnt_q <= CW'(PULSE_LEN);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

  assign wake_n = (cnt_q == '0);

  p_fire_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> !wake_armed);
  p_fire_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> $past(wake_armed));
  p_status_on_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> wake_status);
  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |=> !wake_n);
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q == '0 || pos_q < total);
  p_write_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> pos_q == '0);
  p_oob_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> rd_data == 8'h00);
endmodule

// File: tb/test_kbd_wake_matcher.sv
module test_kbd_wake_matcher;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic idx_wr = 0, dat_wr = 0, kb_valid = 0, ms_click = 0, ms_right = 0;
  logic any_key = 0, mouse_en = 0, mouse_sel_right = 0, arm = 0;
  logic [3:0] idx_wdata = 0;
  logic [7:0] dat_wdata = 0, kb_byte = 0, rd_data;
  logic wake_armed, wake_status, wake_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_wake_matcher i_kbd_wake_matcher (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); idx_wr = 1; idx_wdata = 4'(a);
    @(negedge clk); idx_wr = 0; dat_wr = 1; dat_wdata = d;
    @(negedge clk); dat_wr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); idx_wr = 1; idx_wdata = 4'(a);
    @(negedge clk); idx_wr = 0; d = rd_data;
  endtask

  task automatic key(input int k, input logic [7:0] m, input logic [7:0] b);
    wr(3*k, m); wr(3*k+1, 8'hF0); wr(3*k+2, b);
  endtask

  task automatic clear_all();
    for (int a = 0; a < 15; a++) wr(a, 8'h00);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic kb(input logic [7:0] b);
    @(negedge clk); kb_valid = 1; kb_byte = b;
    @(negedge clk); kb_valid = 0;
  endtask

  task automatic click(input logic r);
    @(negedge clk); ms_click = 1; ms_right = r;
    @(negedge clk); ms_click = 0;
  endtask

  task automatic expect_wake(input string tag);
    int n = 0;
    chk(wake_n == 0, tag, wake_n, 0);
    while (!wake_n && n < 100) begin n++; @(negedge clk); end
    chk(n == 16, {tag, " R8 pulse length"}, n, 16);
    chk(wake_armed == 0 && wake_status == 1, {tag, " R9 R10 flags"},
        {wake_armed, wake_status}, 1);
  endtask

  task automatic expect_quiet(input string tag);
    int low = 0;
    for (int i = 0; i < 4; i++) begin if (!wake_n) low++; @(negedge clk); end
    chk(low == 0, tag, low, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(wake_n == 1 && wake_armed == 0 && wake_status == 0, "R1 reset outputs",
        {wake_n, wake_armed, wake_status}, 3'b100);
    rd(7, d); chk(d == 0, "R1 storage zero", d, 0);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    for (int a = 0; a < 15; a++) wr(a, 8'(8'h30 + a));
    for (int a = 0; a < 15; a++) begin rd(a, d); chk(d == 8'(8'h30 + a), "R2 readback", d, 8'h30 + a); end
    wr(15, 8'hAA); rd(15, d); chk(d == 0, "R2 index 0Fh", d, 0);
    rd(0, d); chk(d == 8'h30, "R2 0Fh write dropped", d, 8'h30);
    clear_all();
  endtask

  task automatic t_full();
    logic [7:0] m [5] = '{8'h1C, 8'h32, 8'h21, 8'h23, 8'h24};
    for (int k = 0; k < 5; k++) key(k, m[k], m[k]);
    do_arm();
    chk(wake_armed == 1 && wake_status == 0, "R10 arm", {wake_armed, wake_status}, 2);
    for (int k = 0; k < 5; k++) begin
      kb(m[k]); kb(8'hF0);
      if (k < 4) kb(m[k]);
    end
    chk(wake_n == 1, "R3 no wake before last byte", wake_n, 1);
    kb(m[4]);
    expect_wake("R3 five-key match");
    for (int k = 0; k < 5; k++) begin kb(m[k]); kb(8'hF0); kb(m[k]); end
    chk(wake_n == 1 && wake_status == 1, "R9 unarmed ignored", {wake_n, wake_status}, 3);
    do_arm();
    chk(wake_status == 0, "R10 arm clears status", wake_status, 0);
  endtask

  task automatic t_short_restart();
    clear_all(); key(0, 8'h11, 8'h11); key(1, 8'h22, 8'h22);
    do_arm();
    kb(8'h11); kb(8'hF0); kb(8'h11); kb(8'h11); kb(8'hF0); kb(8'h11);
    kb(8'h22); kb(8'hF0); kb(8'h22);
    expect_wake("R5 R4 restart and short password");
    do_arm();
    kb(8'h11); kb(8'hF0); kb(8'h22); kb(8'hF0); kb(8'h22);
    expect_quiet("R5 broken sequence");
    kb(8'h11); kb(8'hF0); kb(8'h11); kb(8'h22); kb(8'hF0); kb(8'h22);
    expect_wake("R4 two-key match");
  endtask

  task automatic t_write_restart();
    do_arm();
    kb(8'h11); kb(8'hF0); kb(8'h11); kb(8'h22);
    wr(14, 8'h00);
    kb(8'hF0); kb(8'h22);
    expect_quiet("R12 write drops progress");
    kb(8'h11); kb(8'hF0); kb(8'h11); kb(8'h22); kb(8'hF0); kb(8'h22);
    expect_wake("R12 retyped match");
  endtask

  task automatic t_any_mouse();
    do_arm(); any_key = 1; kb(8'h5A);
    expect_wake("R6 any key"); any_key = 0;
    do_arm(); click(0); expect_quiet("R7 mouse disabled");
    mouse_en = 1; mouse_sel_right = 0;
    click(1); expect_quiet("R7 right ignored when left chosen");
    click(0); expect_wake("R7 left click");
    do_arm(); mouse_sel_right = 1;
    click(0); expect_quiet("R7 left ignored when right chosen");
    click(1); expect_wake("R7 right click");
    mouse_en = 0;
  endtask

  task automatic t_empty();
    clear_all(); key(1, 8'h33, 8'h33); do_arm();
    kb(8'h00); kb(8'h33); kb(8'hF0); kb(8'h33); kb(8'h00);
    expect_quiet("R11 empty password");
    chk(wake_armed == 1, "R11 still armed", wake_armed, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_full();
    t_short_restart();
    t_write_restart();
    t_any_mouse();
    t_empty();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule